// File: doc/BRIEF.md
# Pulsed-Sync Serial Frame Master

This block is a serial master that sends words in the pulsed-sync frame format. A write port feeds a small transmit FIFO. For each word, the master raises the frame-sync line for one serial clock period. It then shifts the word out MSB first on `mosi`. At the same time it samples `miso` and returns each received word with a one-cycle strobe. The serial clock is the system clock divided by a parameter. Each half of the serial clock period lasts `CLK_DIV` system cycles.

Two mode inputs change the framing.

- **Merge mode:** while words arrive back to back, only the first word of a burst gets a sync pulse. The burst then looks like one long frame.
- **Free-running mode:** the serial clock keeps toggling when no frame is in progress.

In the default mode, the clock is gated. It rests low and toggles only during sync and data periods.

Top module: `ssf_master`

## Requirements
- R1: While reset is asserted, `sclk`, `fss`, `mosi` and `rx_valid` are 0, and `wr_ready` is 1.
- R2: A serial clock period is `2*CLK_DIV` system cycles. It starts with `sclk` rising and has `sclk` high for the first `CLK_DIV` cycles. With `free_run` low, `sclk` stays low whenever no frame is in progress.
- R3: `fss` idles low. It is high for exactly one serial period, and that period directly precedes the MSB period of a frame.
- R4: `mosi` carries the word MSB first, one bit per serial period. It changes only together with a rising edge of the internal period phase. It is 0 outside data periods.
- R5: `miso` is sampled on each falling edge of `sclk` during data periods, and the samples are assembled MSB first. After the LSB sample, `rx_data` holds the word and `rx_valid` is high for exactly one system cycle.
- R6: With `merge_en` low, if a word is waiting when the LSB period ends, the next period is a sync period for that word. If no word is waiting, the master goes idle.
- R7: With `merge_en` high, if a word is waiting when the LSB period ends, its MSB period follows at once with no sync period. A frame that starts from idle still gets a sync period.
- R8: With `free_run` high, `sclk` toggles continuously with the R2 period, including while idle. Frames stay aligned to its periods.
- R9: The FIFO holds `FIFO_DEPTH` words. `wr_ready` is low exactly when it is full. A write presented while `wr_ready` is low is dropped, and words are sent in write order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| merge_en | input | 1 | Suppress sync on back-to-back frames |
| free_run | input | 1 | Keep the serial clock toggling while idle |
| wr_valid | input | 1 | Write strobe for the transmit FIFO |
| wr_data | input | DATA_W | Word to transmit |
| wr_ready | output | 1 | FIFO can accept a word |
| sclk | output | 1 | Serial clock |
| fss | output | 1 | Active-high frame-sync pulse |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| rx_valid | output | 1 | One-cycle strobe for a received word |
| rx_data | output | DATA_W | Last received word |

## Verification
The assertions assume the mode inputs and `miso` are steady across each system clock edge. They do not assume the mode inputs are steady over a whole frame: the merge choice is taken only when a period ends, and `free_run` only gates the clock output.

The stimulus changes inputs on the falling system edge. It flips `merge_en` and `free_run` only between frames, except for one flip of `merge_en` inside a burst. It holds `wr_valid` against a full FIFO on purpose so that dropped writes are exercised.

// File: rtl/ssf_master.sv
module ssf_master #(
  parameter int DATA_W     = 8,
  parameter int CLK_DIV    = 2,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              merge_en,
  input  logic              free_run,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  output logic              sclk,
  output logic              fss,
  output logic              mosi,
  input  logic              miso,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data
);
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int AW    = $clog2(FIFO_DEPTH);
  localparam int BIT_W = $clog2(DATA_W);

  typedef enum logic [1:0] {S_IDLE, S_SYNC, S_DATA} st_t;

  st_t               st;
  logic [DIV_W-1:0]  cnt;
  logic              hi;
  logic [BIT_W-1:0]  bitc;
  logic [DATA_W-1:0] sh, rsh;
  logic [DATA_W-1:0] mem [FIFO_DEPTH];
  logic [AW:0]       wp, rp;
  logic [AW:0]       fill;
  logic              tick, pstart, fall, empty, push, pop, last, active;

  assign tick   = cnt == DIV_W'(CLK_DIV - 1);
  assign pstart = tick & ~hi;
  assign fall   = tick & hi;
  assign fill   = wp - rp;
  assign empty  = fill == '0;
  assign wr_ready = fill != (AW+1)'(FIFO_DEPTH);
  assign push   = wr_valid & wr_ready;
  assign last   = bitc == '0;
  assign pop    = pstart & ~empty & (st == S_IDLE || (st == S_DATA && last));
  assign active = st != S_IDLE;

  assign sclk = (active | free_run) & hi;
  assign fss  = st == S_SYNC;
  assign mosi = (st == S_DATA) & sh[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt <= '0;
      hi  <= 1'b0;
    end else begin
      cnt <= tick ? '0 : cnt + 1'b1;
      if (tick) hi <= ~hi;
    end

  always_ff @(posedge clk)
    if (push) mem[wp[AW-1:0]] <= wr_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st   <= S_IDLE;
      bitc <= '0;
      sh   <= '0;
    end else if (pstart) begin
      case (st)
        S_IDLE:
          if (!empty) begin
            sh <= mem[rp[AW-1:0]];
            st <= S_SYNC;
          end
        S_SYNC: begin
          st   <= S_DATA;
          bitc <= BIT_W'(DATA_W - 1);
        end
        default:
          if (last) begin
            if (!empty) begin
              sh   <= mem[rp[AW-1:0]];
              bitc <= BIT_W'(DATA_W - 1);
              st   <= merge_en ? S_DATA : S_SYNC;
            end else begin
              st <= S_IDLE;
            end
          end else begin
            bitc <= bitc - 1'b1;
            sh   <= sh << 1;
          end
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rsh      <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (fall && st == S_DATA) begin
        rsh <= {rsh[DATA_W-2:0], miso};
        if (last) begin
          rx_data  <= {rsh[DATA_W-2:0], miso};
          rx_valid <= 1'b1;
        end
      end
    end
endmodule

// File: rtl/ssf_master_chk.sv
module ssf_master_chk #(
  parameter int CLK_DIV    = 2,
  parameter int FIFO_DEPTH = 4,
  parameter int FW         = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          free_run,
  input logic          sclk,
  input logic          fss,
  input logic          mosi,
  input logic          rx_valid,
  input logic          hi,
  input logic [FW-1:0] fill
);
  int hi_run, fss_run;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hi_run  <= 0;
      fss_run <= 0;
    end else begin
      hi_run  <= sclk ? hi_run + 1 : 0;
      fss_run <= fss ? fss_run + 1 : 0;
    end

  assert_sclk_half_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hi_run <= CLK_DIV);
  assert_sync_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fss_run <= 2 * CLK_DIV);
  assert_mosi_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mosi) |-> $rose(hi));
  assert_rx_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  assert_free_clock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    free_run |-> (sclk == hi));
  assert_fill_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fill) <= FIFO_DEPTH);
endmodule

bind ssf_master ssf_master_chk #(
  .CLK_DIV(CLK_DIV), .FIFO_DEPTH(FIFO_DEPTH), .FW(AW + 1)
) u_chk (
  .clk(clk), .rst_n(rst_n), .free_run(free_run), .sclk(sclk), .fss(fss),
  .mosi(mosi), .rx_valid(rx_valid), .hi(hi), .fill(fill)
);

// File: tb/test_ssf_master.sv
`timescale 1ns/1ps
module test_ssf_master;
  localparam int W = 8, DIV = 2, DEPTH = 4;

  logic clk = 0, rst_n = 0;
  logic merge_en = 0, free_run = 0, wr_valid = 0, miso = 0;
  logic [W-1:0] wr_data = '0;
  logic wr_ready, sclk, fss, mosi, rx_valid;
  logic [W-1:0] rx_data;

  ssf_master #(.DATA_W(W), .CLK_DIV(DIV), .FIFO_DEPTH(DEPTH)) i_ssf_master (
    .clk(clk), .rst_n(rst_n), .merge_en(merge_en), .free_run(free_run),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready), .sclk(sclk),
    .fss(fss), .mosi(mosi), .miso(miso), .rx_valid(rx_valid), .rx_data(rx_data));

  always #2.5 clk = ~clk;

  int compared = 0, mismatched = 0, cycles = 0;
  bit done = 0;

  // behavioural model: 0 idle, 1 sync, 2 data
  logic [W-1:0] q[$];
  int m_cnt, m_st, m_bit;
  bit m_hi, m_rxv;
  logic [W-1:0] m_word, m_rsh, m_rxd;

  task automatic cmp(input string req, input string nm, input logic [W-1:0] act, input logic [W-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual %0h expected %0h at cycle %0d", req, nm, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    bit tk, pst, fl, accept;
    cycles++;
    if (!rst_n) begin
      q.delete(); m_cnt = 0; m_st = 0; m_bit = 0; m_hi = 0; m_rxv = 0;
      m_word = '0; m_rsh = '0; m_rxd = '0;
    end else begin
      m_rxv = 0;
      tk = (m_cnt == DIV - 1);
      pst = tk && !m_hi;
      fl = tk && m_hi;
      accept = wr_valid && q.size() < DEPTH;
      if (fl && m_st == 2) begin
        m_rsh = {m_rsh[W-2:0], miso};
        if (m_bit == 0) begin m_rxd = m_rsh; m_rxv = 1; end
      end
      if (pst) begin
        if (m_st == 0) begin
          if (q.size() > 0) begin m_word = q.pop_front(); m_st = 1; end
        end else if (m_st == 1) begin
          m_st = 2; m_bit = W - 1;
        end else if (m_bit == 0) begin
          if (q.size() > 0) begin
            m_word = q.pop_front(); m_bit = W - 1; m_st = merge_en ? 2 : 1;
          end else m_st = 0;
        end else m_bit--;
      end
      m_cnt = tk ? 0 : m_cnt + 1;
      if (tk) m_hi = !m_hi;
      if (accept) q.push_back(wr_data);
    end
    #1;
    if (!done) begin
      cmp("R2/R8", "sclk", W'(sclk), W'((m_st != 0 || free_run) && m_hi));
      cmp("R3", "fss", W'(fss), W'(m_st == 1));
      cmp("R4", "mosi", W'(mosi), W'(m_st == 2 ? m_word[m_bit] : 1'b0));
      cmp("R5", "rx_valid", W'(rx_valid), W'(m_rxv));
      cmp("R5", "rx_data", rx_data, m_rxd);
      cmp("R9", "wr_ready", W'(wr_ready), W'(q.size() < DEPTH));
    end
  end

  // slave data pattern
  logic [7:0] lfsr = 8'h5B;
  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    miso <= lfsr[0];
  end

  task automatic put(input logic [W-1:0] d);
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    wr_valid = 1; wr_data = d;
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic wait_idle();
    int n = 0;
    @(negedge clk);
    while ((q.size() != 0 || m_st != 0) && n < 5000) begin @(negedge clk); n++; end
    repeat (8) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    cmp("R1", "sclk", W'(sclk), '0);
    cmp("R1", "fss", W'(fss), '0);
    cmp("R1", "mosi", W'(mosi), '0);
    cmp("R1", "rx_valid", W'(rx_valid), '0);
    cmp("R1", "wr_ready", W'(wr_ready), W'(1));
    rst_n = 1;
    repeat (6) @(negedge clk);
    // R2 R3 R4 R5: single frame, gated clock
    put(8'hA5);
    wait_idle();
    // R6: back-to-back frames with a sync period each
    put(8'h3C); put(8'hFF); put(8'h01);
    wait_idle();
    // R7: merged burst, then merge dropped mid-burst
    merge_en = 1;
    put(8'h81); put(8'h7E); put(8'h00); put(8'hC3);
    wait_idle();
    put(8'h55); put(8'hAA);
    repeat (20) @(negedge clk);
    merge_en = 0;
    wait_idle();
    // R8: free-running clock, idle and during frames
    free_run = 1;
    repeat (13) @(negedge clk);
    put(8'h96); put(8'h69);
    wait_idle();
    merge_en = 1;
    put(8'hE1); put(8'h1E);
    wait_idle();
    free_run = 0; merge_en = 0;
    repeat (5) @(negedge clk);
    // R9: writes held against a full FIFO are dropped
    @(negedge clk);
    for (int i = 0; i < 12; i++) begin
      wr_valid = 1; wr_data = W'(8'h10 + i);
      @(negedge clk);
    end
    wr_valid = 0;
    wait_idle();
    finish_run();
  end

  initial begin
    #400000;
    mismatched++;
    $display("FAIL watchdog actual running expected finished");
    finish_run();
  end
endmodule